// File: doc/BRIEF.md
# Raster Display Timing and Base Address Register Bank

This block holds the programmable settings of a raster scanout engine. These are the visible resolution in both axes, the sync window and total scan length for each axis, the start address of the pixel buffer in memory, a burst length for memory fetches, a display-data-channel word and a pixel-clock selector word. A processor reaches them through a plain 32-bit word bus. The bus has separate read and write strobes, a byte address, write data, and read data that is registered.

Each stored value is wired straight to the scanout logic. The block also gives an active-high enable, which is high when the soft-reset bit in the control word is clear. Two single-cycle notification pulses tell the scanout logic when to re-evaluate. One fires when the screen geometry may have changed, and the other when a new buffer base has been accepted.

The buffer base must be 32-byte aligned. A write that breaks this rule is dropped without any effect. An accepted base is trimmed by a build-time address mask. A read-only slot placed directly after the base reports the base that is in force.

Top module: `raster_csr`

## Requirements
- R1: After reset, the control word reads 1 and `enable` is low. The horizontal width reads 640 and the vertical height reads 480. Every other slot, including the base, reads 0.
- R2: Register slots are selected by byte address bits [5:2], in this order: 0 control, 1 horizontal width, 2 hsync start, 3 hsync end, 4 horizontal total, 5 vertical height, 6 vsync start, 7 vsync end, 8 vertical total, 9 base, 10 active base, 11 burst, 12 DDC word, 13 clock word. A write to any writable slot other than the base stores the full 32-bit word, which then appears on that slot's output port and on readback.
- R3: `enable` is high exactly when bit 0 of the control word is 0. It follows a control write from the cycle after the write strobe.
- R4: A base write whose data has any of bits [4:0] set is discarded. The base keeps its previous value and no base pulse fires.
- R5: An aligned base write stores the write data ANDed with the parameter `BASE_MASK`.
- R6: Reading slot 10 returns the current base. Writes to slot 10 change nothing.
- R7: Byte address bits [1:0] are ignored.
- R8: A read at slot index 14 or above returns 0. A write there changes no register.
- R9: `geom_pulse` is high for exactly one cycle, the cycle after a write to slot 0, 1 or 5, and at no other time. `base_pulse` is high for exactly one cycle after an accepted base write, and at no other time.
- R10: `bus_rdata` is loaded on the clock edge at which `bus_rd` is sampled high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| enable | output | 1 | Scanout enable (control bit 0 clear) |
| ctrl_word | output | 32 | Control word |
| h_res | output | 32 | Horizontal visible width |
| h_sync_beg | output | 32 | Horizontal sync start |
| h_sync_end | output | 32 | Horizontal sync end |
| h_total | output | 32 | Horizontal total scan length |
| v_res | output | 32 | Vertical visible height |
| v_sync_beg | output | 32 | Vertical sync start |
| v_sync_end | output | 32 | Vertical sync end |
| v_total | output | 32 | Vertical total scan length |
| fb_base | output | 32 | Pixel buffer base address |
| burst_len | output | 32 | Memory burst length |
| ddc_word | output | 32 | Display data channel word |
| clk_word | output | 32 | Pixel clock selector word |
| geom_pulse | output | 1 | One-cycle geometry-change notice |
| base_pulse | output | 1 | One-cycle new-base notice |

## Verification
Every stored slot drives its own output port, so a corrupted register appears on that port in the very next cycle, before any readback. A wrong slot decode moves a written value to a neighbouring port. A broken alignment or mask path leaves an unexpected value on `fb_base` one cycle after the write, and the same value comes back through the read-only mirror one cycle after a read. An error in the pulse logic is visible in the single cycle after the write strobe: a pulse is missing, fires for the wrong slot, or lasts longer than one cycle.

// File: rtl/raster_csr_pkg.sv
package raster_csr_pkg;
  localparam int CSR_DW  = 32;
  localparam int NREG    = 14;
  localparam int SLOT_W  = $clog2(NREG);

  localparam int IX_CTRL  = 0;
  localparam int IX_HRES  = 1;
  localparam int IX_HSB   = 2;
  localparam int IX_HSE   = 3;
  localparam int IX_HTOT  = 4;
  localparam int IX_VRES  = 5;
  localparam int IX_VSB   = 6;
  localparam int IX_VSE   = 7;
  localparam int IX_VTOT  = 8;
  localparam int IX_BASE  = 9;
  localparam int IX_ACT   = 10;
  localparam int IX_BURST = 11;
  localparam int IX_DDC   = 12;
  localparam int IX_CLK   = 13;

  function automatic logic [CSR_DW-1:0] rst_val(input int idx);
    case (idx)
      IX_CTRL: rst_val = 32'd1;
      IX_HRES: rst_val = 32'd640;
      IX_VRES: rst_val = 32'd480;
      default: rst_val = '0;
    endcase
  endfunction
endpackage

// File: rtl/raster_csr_decode.sv
module raster_csr_decode
  import raster_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-3:0] word_idx,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);
  localparam int IDX_W = ADDR_W - 2;

  always_comb begin
    hit  = (word_idx < IDX_W'(NREG));
    slot = word_idx[SLOT_W-1:0];
  end
endmodule

// File: rtl/raster_csr_store.sv
module raster_csr_store
  import raster_csr_pkg::*;
#(
  parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF,
  parameter int          ALIGN_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              hit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [CSR_DW-1:0] wdata,
  output logic [CSR_DW-1:0] q [NREG],
  output logic              geom_pulse,
  output logic              base_pulse
);
  logic wr_ok;
  logic aligned;

  assign wr_ok   = we && hit;
  assign aligned = (wdata[ALIGN_W-1:0] == '0);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic sel;
    assign sel = wr_ok && (slot == SLOT_W'(i));
    if (i == IX_ACT) begin : g_mirror
      assign q[i] = q[IX_BASE];
    end else if (i == IX_BASE) begin : g_base
      logic [CSR_DW-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)                r <= rst_val(i);
        else if (sel && aligned) r <= wdata & BASE_MASK;
      end
      assign q[i] = r;
    end else begin : g_plain
      logic [CSR_DW-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)      r <= rst_val(i);
        else if (sel) r <= wdata;
      end
      assign q[i] = r;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      geom_pulse <= 1'b0;
      base_pulse <= 1'b0;
    end else begin
      geom_pulse <= wr_ok && (slot == SLOT_W'(IX_CTRL) ||
                              slot == SLOT_W'(IX_HRES) ||
                              slot == SLOT_W'(IX_VRES));
      base_pulse <= wr_ok && aligned && (slot == SLOT_W'(IX_BASE));
    end
  end
endmodule

// File: rtl/raster_csr_readout.sv
module raster_csr_readout
  import raster_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic              hit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [CSR_DW-1:0] q [NREG],
  output logic [CSR_DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= hit ? q[slot] : '0;
  end
endmodule

// File: rtl/raster_csr.sv
module raster_csr
  import raster_csr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF,
  parameter int          ALIGN_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              enable,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       h_res,
  output logic [31:0]       h_sync_beg,
  output logic [31:0]       h_sync_end,
  output logic [31:0]       h_total,
  output logic [31:0]       v_res,
  output logic [31:0]       v_sync_beg,
  output logic [31:0]       v_sync_end,
  output logic [31:0]       v_total,
  output logic [31:0]       fb_base,
  output logic [31:0]       burst_len,
  output logic [31:0]       ddc_word,
  output logic [31:0]       clk_word,
  output logic              geom_pulse,
  output logic              base_pulse
);
  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic [CSR_DW-1:0] q [NREG];

  raster_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .word_idx (bus_addr[ADDR_W-1:2]),
    .hit      (hit),
    .slot     (slot)
  );

  raster_csr_store #(.BASE_MASK(BASE_MASK), .ALIGN_W(ALIGN_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .we         (bus_wr),
    .hit        (hit),
    .slot       (slot),
    .wdata      (bus_wdata),
    .q          (q),
    .geom_pulse (geom_pulse),
    .base_pulse (base_pulse)
  );

  raster_csr_readout u_rd (
    .clk   (clk),
    .rst   (rst),
    .re    (bus_rd),
    .hit   (hit),
    .slot  (slot),
    .q     (q),
    .rdata (bus_rdata)
  );

  assign ctrl_word  = q[IX_CTRL];
  assign enable     = ~q[IX_CTRL][0];
  assign h_res      = q[IX_HRES];
  assign h_sync_beg = q[IX_HSB];
  assign h_sync_end = q[IX_HSE];
  assign h_total    = q[IX_HTOT];
  assign v_res      = q[IX_VRES];
  assign v_sync_beg = q[IX_VSB];
  assign v_sync_end = q[IX_VSE];
  assign v_total    = q[IX_VTOT];
  assign fb_base    = q[IX_BASE];
  assign burst_len  = q[IX_BURST];
  assign ddc_word   = q[IX_DDC];
  assign clk_word   = q[IX_CLK];
endmodule

// File: rtl/raster_csr_chk.sv
module raster_csr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              enable,
  input logic [31:0]       fb_base,
  input logic              geom_pulse,
  input logic              base_pulse
);
  logic [ADDR_W-3:0] idx;
  logic              geo_wr;
  assign idx    = bus_addr[ADDR_W-1:2];
  assign geo_wr = bus_wr && (idx == 0 || idx == 1 || idx == 5);

  AST_GEOM_FIRES: assert property (@(posedge clk) disable iff (rst)
    geo_wr |=> geom_pulse); // R9
  AST_GEOM_QUIET: assert property (@(posedge clk) disable iff (rst)
    !geo_wr |=> !geom_pulse); // R9
  AST_BASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && idx == 9) |=> !base_pulse); // R9
  AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 9 && bus_wdata[4:0] != 5'd0) |=> ($stable(fb_base) && !base_pulse)); // R4
  AST_MIRROR_RO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 10) |=> $stable(fb_base)); // R6
  AST_ENABLE_BIT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 0) |=> (enable == !$past(bus_wdata[0]))); // R3
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx >= 14) |=> (bus_rdata == 32'd0)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

bind raster_csr raster_csr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_raster_csr.sv
module sim_raster_csr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, ctrl_word, h_res, h_sync_beg, h_sync_end, h_total;
  logic [31:0] v_res, v_sync_beg, v_sync_end, v_total, fb_base, burst_len;
  logic [31:0] ddc_word, clk_word;
  logic        enable, geom_pulse, base_pulse;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  raster_csr #(.ADDR_W(8), .BASE_MASK(32'h00FF_FFFF)) u0 (.*);

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 32'd800,        32'd800,        4'd2}, // R2
    '{8'h08, 32'd856,        32'd856,        4'd2}, // R2
    '{8'h0C, 32'd976,        32'd976,        4'd2}, // R2
    '{8'h10, 32'd1040,       32'd1040,       4'd2}, // R2
    '{8'h14, 32'd600,        32'd600,        4'd2}, // R2
    '{8'h18, 32'd637,        32'd637,        4'd2}, // R2
    '{8'h1C, 32'd643,        32'd643,        4'd2}, // R2
    '{8'h20, 32'd666,        32'd666,        4'd2}, // R2
    '{8'h2C, 32'd4,          32'd4,          4'd2}, // R2
    '{8'h30, 32'h0000_00A5,  32'h0000_00A5,  4'd2}, // R2
    '{8'h34, 32'hCAFE_1234,  32'hCAFE_1234,  4'd2}, // R2
    '{8'h24, 32'hFF00_0040,  32'h0000_0040,  4'd5}, // R5 masked
    '{8'h24, 32'h0000_0123,  32'h0000_0040,  4'd4}, // R4 misaligned kept
    '{8'h28, 32'hDEAD_0000,  32'h0000_0040,  4'd6}, // R6 read-only mirror
    '{8'h38, 32'h0000_0005,  32'h0000_0000,  4'd8}, // R8
    '{8'h3C, 32'hFFFF_FFFF,  32'h0000_0000,  4'd8}  // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                          output logic g, output logic b);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    g = geom_pulse; b = base_pulse;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic g, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 enable", {31'd0, enable}, 32'd0);
    do_read(8'h00, rd); check("R1 ctrl", rd, 32'd1);
    do_read(8'h04, rd); check("R1 hres", rd, 32'd640);
    do_read(8'h14, rd); check("R1 vres", rd, 32'd480);
    do_read(8'h24, rd); check("R1 base", rd, 32'd0);
    do_read(8'h08, rd); check("R1 hsync", rd, 32'd0);
    do_read(8'h34, rd); check("R1 clk", rd, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].addr, VECS[i].wdata, g, b);
      do_read(VECS[i].addr, rd);
      checks++;
      if (rd !== VECS[i].exp) begin
        errors++;
        $display("FAIL R%0d vec %0d: actual=%h expected=%h", VECS[i].req, i, rd, VECS[i].exp);
      end
    end

    // R2 output ports
    check("R2 h_res", h_res, 32'd800);
    check("R2 v_total", v_total, 32'd666);
    check("R2 clk_word", clk_word, 32'hCAFE_1234);
    // R8 out-of-range writes touched nothing
    check("R8 fb_base", fb_base, 32'h40);
    check("R8 ddc", ddc_word, 32'hA5);
    check("R8 burst", burst_len, 32'd4);

    // R3 and R9 control write
    do_write(8'h00, 32'd0, g, b);
    check("R9 geom on ctrl", {31'd0, g}, 32'd1);
    check("R3 enable on", {31'd0, enable}, 32'd1);
    @(negedge clk);
    check("R9 geom single", {31'd0, geom_pulse}, 32'd0);
    do_write(8'h00, 32'd1, g, b);
    check("R3 enable off", {31'd0, enable}, 32'd0);
    check("R3 ctrl port", ctrl_word, 32'd1);
    do_write(8'h08, 32'd9, g, b);
    check("R9 no geom hsync", {31'd0, g}, 32'd0);
    do_write(8'h14, 32'd768, g, b);
    check("R9 geom on vres", {31'd0, g}, 32'd1);

    // R9 base pulses, R4 no pulse
    do_write(8'h24, 32'h0000_1000, g, b);
    check("R9 base pulse", {31'd0, b}, 32'd1);
    check("R5 base port", fb_base, 32'h1000);
    @(negedge clk);
    check("R9 base single", {31'd0, base_pulse}, 32'd0);
    do_write(8'h24, 32'h0000_2010, g, b);
    check("R4 no pulse", {31'd0, b}, 32'd0);
    check("R4 base kept", fb_base, 32'h1000);
    do_write(8'h28, 32'h0000_3000, g, b);
    check("R6 no pulse", {31'd0, b}, 32'd0);
    do_read(8'h28, rd); check("R6 mirror", rd, 32'h1000);

    // R7 low address bits ignored
    do_write(8'h2D, 32'd7, g, b);
    check("R7 burst port", burst_len, 32'd7);
    do_read(8'h2E, rd); check("R7 readback", rd, 32'd7);

    // R10 registered read timing
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h04;
    #1 check("R10 before edge", bus_rdata, 32'd7);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 8'h14;
    check("R10 after edge", bus_rdata, 32'd800);
    @(negedge clk);
    check("R10 hold", bus_rdata, 32'd800);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule